// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block holds the transmit and receive word queues of a serial peripheral controller. The same unit reports the state of those queues to software. Software fills the transmit queue and drains the receive queue through a simple indexed register port. The serial engine pops transmit words and pushes received words through a separate side port. The unit derives a status register, a raw interrupt register, a mask and a masked view from the two queue levels and from sticky error flags. It reduces them to one interrupt line and raises two DMA request lines from independent watermarks.

The block has an enable bit. While the enable bit is clear, both queues are held empty and the threshold registers may be programmed. While it is set, traffic flows and the thresholds are frozen. Every threshold and watermark register refuses values at or above the queue depth. Software can therefore find the depth by writing large values and reading them back.

Top module: `spi_fifo_stat`

## Requirements
- R1: After reset, all levels read 0, status reads 0x0C (TX empty bit 2, RX empty bit 3), raw interrupts read 0x01, and `irq`, `dma_tx_req` and `dma_rx_req` are low.
- R2: Words written to the TX data register (index 13) leave on `eng_tx_data` in write order, one cycle after `eng_tx_pop`. Words pushed by the engine are returned in push order by reads of the RX data register (index 14). The level registers (TX index 3, RX index 4) report the current word counts.
- R3: A TX data write while the TX queue holds DEPTH words is dropped and sets raw bit 1. Status bit 1 reads 1 while the TX queue is full.
- R4: A read of the RX data register while the RX queue is empty returns 0 and sets raw bit 2.
- R5: An engine push while the RX queue is full is dropped and sets raw bit 3. Status bit 4 reads 1 while the RX queue is full.
- R6: Raw bit 4 is 1 exactly when the RX level is strictly greater than the RX threshold (index 2).
- R7: Raw bit 0 is 1 exactly when the TX level is at or below the TX threshold (index 1).
- R8: A threshold write with a value of DEPTH or more leaves the register unchanged, as does any threshold write while the enable bit (index 0, bit 0) is set.
- R9: A write to the clear register (index 9) clears the sticky flags as follows: bit 3 clears TX overflow, bit 2 clears RX overflow, bit 1 clears RX underflow, and bit 0 clears all three.
- R10: `irq` is high one cycle after any raw bit is set whose mask bit (index 6) is set. The masked register (index 7) reads raw AND mask.
- R11: With DMA enable (index 10) bit 1 set, `dma_tx_req` is high, one cycle later, while TX level is at or below the TX watermark (index 11). With bit 0 set, `dma_rx_req` is high while RX level exceeds the RX watermark (index 12).
- R12: While the enable bit is clear, both queues are emptied and TX data writes and engine pushes are dropped.
- R13: Status bit 0 follows the engine's `eng_busy` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_addr | input | 4 | register index |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data, valid the cycle after `reg_rd` |
| eng_busy | input | 1 | serial engine is shifting |
| eng_tx_pop | input | 1 | engine takes one TX word |
| eng_tx_data | output | DATA_W | TX word popped on the previous cycle |
| eng_tx_valid | output | 1 | TX queue not empty |
| eng_rx_push | input | 1 | engine delivers one RX word |
| eng_rx_data | input | DATA_W | RX word to store |
| irq | output | 1 | masked interrupt line |
| dma_tx_req | output | 1 | TX DMA request |
| dma_rx_req | output | 1 | RX DMA request |

## Verification
The bench builds the unit with DEPTH 4 and DATA_W 8. With these values both queues fill after four words, so overflow and the full status bits are reached in a few cycles. The largest legal threshold is 3, so writing 4 exercises the out-of-range rejection. Thresholds and watermarks of 1 put the strict-greater and at-or-below comparisons one word away from each edge.

// File: rtl/spi_fifo_stat_pkg.sv
package spi_fifo_stat_pkg;

  typedef enum logic [3:0] {
    RA_CTRL  = 4'd0,
    RA_TXTHR = 4'd1,
    RA_RXTHR = 4'd2,
    RA_TXLVL = 4'd3,
    RA_RXLVL = 4'd4,
    RA_STAT  = 4'd5,
    RA_MASK  = 4'd6,
    RA_ISTAT = 4'd7,
    RA_RAW   = 4'd8,
    RA_CLR   = 4'd9,
    RA_DMAEN = 4'd10,
    RA_TXWM  = 4'd11,
    RA_RXWM  = 4'd12,
    RA_TXD   = 4'd13,
    RA_RXD   = 4'd14
  } reg_idx_e;

  // status bit positions
  localparam int ST_BUSY    = 0;
  localparam int ST_TXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_RXEMPTY = 3;
  localparam int ST_RXFULL  = 4;

  // interrupt bit positions
  localparam int IB_TXLOW = 0;
  localparam int IB_TXOVF = 1;
  localparam int IB_RXUDF = 2;
  localparam int IB_RXOVF = 3;
  localparam int IB_RXTHR = 4;
  localparam int IRQ_W    = 5;

  // clear register bit positions
  localparam int CB_ALL   = 0;
  localparam int CB_RXUDF = 1;
  localparam int CB_RXOVF = 2;
  localparam int CB_TXOVF = 3;
  localparam int CLR_W    = 4;

  // DMA enable bit positions
  localparam int DE_RX = 0;
  localparam int DE_TX = 1;

endpackage

// File: rtl/spi_fifo_stat_fifo.sv
module spi_fifo_stat_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  level,
  output logic              full,
  output logic              empty
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign level   = cnt_q;
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

  // synchronous read port
  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (do_pop) rdata <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/spi_fifo_stat_irq.sv
module spi_fifo_stat_irq
  import spi_fifo_stat_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int THR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [THR_W-1:0] rx_thr,
  input  logic             set_txo,
  input  logic             set_rxu,
  input  logic             set_rxo,
  input  logic [CLR_W-1:0] clr,
  input  logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] raw,
  output logic             irq
);

  logic txo_q, rxu_q, rxo_q;
  logic tx_low, rx_thr_hit;

  assign tx_low     = (tx_level <= CNT_W'(tx_thr));
  assign rx_thr_hit = (rx_level >  CNT_W'(rx_thr));

  always_comb begin
    raw           = '0;
    raw[IB_TXLOW] = tx_low;
    raw[IB_TXOVF] = txo_q;
    raw[IB_RXUDF] = rxu_q;
    raw[IB_RXOVF] = rxo_q;
    raw[IB_RXTHR] = rx_thr_hit;
  end

  // sticky flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      txo_q <= 1'b0;
      rxu_q <= 1'b0;
      rxo_q <= 1'b0;
    end else begin
      if (set_txo)                         txo_q <= 1'b1;
      else if (clr[CB_ALL] || clr[CB_TXOVF]) txo_q <= 1'b0;
      if (set_rxu)                         rxu_q <= 1'b1;
      else if (clr[CB_ALL] || clr[CB_RXUDF]) rxu_q <= 1'b0;
      if (set_rxo)                         rxo_q <= 1'b1;
      else if (clr[CB_ALL] || clr[CB_RXOVF]) rxo_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(raw & mask);
  end

endmodule

// File: rtl/spi_fifo_stat_dma.sv
module spi_fifo_stat_dma #(
  parameter int CNT_W = 4,
  parameter int THR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [THR_W-1:0] tx_wm,
  input  logic [THR_W-1:0] rx_wm,
  output logic             tx_req,
  output logic             rx_req
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req <= 1'b0;
      rx_req <= 1'b0;
    end else begin
      tx_req <= tx_en & (tx_level <= CNT_W'(tx_wm));
      rx_req <= rx_en & (rx_level >  CNT_W'(rx_wm));
    end
  end

endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
  import spi_fifo_stat_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int AW     = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_tx_pop,
  output logic [DATA_W-1:0] eng_tx_data,
  output logic              eng_tx_valid,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic              irq,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);

  logic             ctrl_en_q;
  logic [THR_W-1:0] tx_thr_q, rx_thr_q, tx_wm_q, rx_wm_q;
  logic [IRQ_W-1:0] mask_q;
  logic [1:0]       dma_en_q;

  logic [CNT_W-1:0]  tx_level, rx_level;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_q;
  logic [IRQ_W-1:0]  raw;
  logic [4:0]        status;

  logic wr_hit_txd, rd_hit_rxd, wr_hit_clr, in_range, thr_ok;
  logic tx_push, rx_push;
  logic [CLR_W-1:0] clr;

  assign wr_hit_txd = reg_wr && (reg_addr == RA_TXD);
  assign rd_hit_rxd = reg_rd && (reg_addr == RA_RXD);
  assign wr_hit_clr = reg_wr && (reg_addr == RA_CLR);
  assign in_range   = (reg_wdata < 32'(DEPTH));
  assign thr_ok     = in_range && !ctrl_en_q;
  assign tx_push    = wr_hit_txd && ctrl_en_q;
  assign rx_push    = eng_rx_push && ctrl_en_q;
  assign clr        = wr_hit_clr ? reg_wdata[CLR_W-1:0] : '0;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en_q <= 1'b0;
      tx_thr_q  <= '0;
      rx_thr_q  <= '0;
      tx_wm_q   <= '0;
      rx_wm_q   <= '0;
      mask_q    <= '0;
      dma_en_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_CTRL:  ctrl_en_q <= reg_wdata[0];
        RA_TXTHR: if (thr_ok)   tx_thr_q <= reg_wdata[THR_W-1:0];
        RA_RXTHR: if (thr_ok)   rx_thr_q <= reg_wdata[THR_W-1:0];
        RA_TXWM:  if (in_range) tx_wm_q  <= reg_wdata[THR_W-1:0];
        RA_RXWM:  if (in_range) rx_wm_q  <= reg_wdata[THR_W-1:0];
        RA_MASK:  mask_q   <= reg_wdata[IRQ_W-1:0];
        RA_DMAEN: dma_en_q <= reg_wdata[1:0];
        default:  ;
      endcase
    end
  end

  spi_fifo_stat_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(~ctrl_en_q),
    .push(tx_push), .wdata(reg_wdata[DATA_W-1:0]),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  spi_fifo_stat_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(~ctrl_en_q),
    .push(rx_push), .wdata(eng_rx_data),
    .pop(rd_hit_rxd), .rdata(rx_q),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  assign eng_tx_valid = ~tx_empty;

  spi_fifo_stat_irq #(.CNT_W(CNT_W), .THR_W(THR_W)) u_irq (
    .clk(clk), .rst(rst),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr_q), .rx_thr(rx_thr_q),
    .set_txo(tx_push && tx_full),
    .set_rxu(rd_hit_rxd && rx_empty),
    .set_rxo(rx_push && rx_full),
    .clr(clr), .mask(mask_q),
    .raw(raw), .irq(irq)
  );

  spi_fifo_stat_dma #(.CNT_W(CNT_W), .THR_W(THR_W)) u_dma (
    .clk(clk), .rst(rst),
    .tx_en(ctrl_en_q & dma_en_q[DE_TX]),
    .rx_en(ctrl_en_q & dma_en_q[DE_RX]),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_wm(tx_wm_q), .rx_wm(rx_wm_q),
    .tx_req(dma_tx_req), .rx_req(dma_rx_req)
  );

  always_comb begin
    status             = '0;
    status[ST_BUSY]    = eng_busy;
    status[ST_TXFULL]  = tx_full;
    status[ST_TXEMPTY] = tx_empty;
    status[ST_RXEMPTY] = rx_empty;
    status[ST_RXFULL]  = rx_full;
  end

  // read path: registered register view, RX data from the queue's read port
  logic        rd_rx_q, rd_udf_q;
  logic [31:0] rd_val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_rx_q  <= 1'b0;
      rd_udf_q <= 1'b0;
      rd_val_q <= '0;
    end else if (reg_rd) begin
      rd_rx_q  <= rd_hit_rxd;
      rd_udf_q <= rd_hit_rxd && rx_empty;
      case (reg_addr)
        RA_CTRL:  rd_val_q <= 32'(ctrl_en_q);
        RA_TXTHR: rd_val_q <= 32'(tx_thr_q);
        RA_RXTHR: rd_val_q <= 32'(rx_thr_q);
        RA_TXLVL: rd_val_q <= 32'(tx_level);
        RA_RXLVL: rd_val_q <= 32'(rx_level);
        RA_STAT:  rd_val_q <= 32'(status);
        RA_MASK:  rd_val_q <= 32'(mask_q);
        RA_ISTAT: rd_val_q <= 32'(raw & mask_q);
        RA_RAW:   rd_val_q <= 32'(raw);
        RA_DMAEN: rd_val_q <= 32'(dma_en_q);
        RA_TXWM:  rd_val_q <= 32'(tx_wm_q);
        RA_RXWM:  rd_val_q <= 32'(rx_wm_q);
        default:  rd_val_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rd_rx_q ? (rd_udf_q ? 32'd0 : 32'(rx_q)) : rd_val_q;

endmodule

// File: rtl/spi_fifo_stat_chk.sv
module spi_fifo_stat_chk
  import spi_fifo_stat_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 4,
  parameter int CNT_W = 4,
  parameter int THR_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [AW-1:0]    reg_addr,
  input logic             ctrl_en,
  input logic             tx_full,
  input logic             rx_empty,
  input logic [IRQ_W-1:0] raw,
  input logic [IRQ_W-1:0] mask,
  input logic [CNT_W-1:0] tx_level,
  input logic [CNT_W-1:0] rx_level,
  input logic [THR_W-1:0] tx_thr,
  input logic [THR_W-1:0] rx_thr,
  input logic [1:0]       dma_en,
  input logic             dma_tx_req,
  input logic             irq
);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= CNT_W'(DEPTH)) && (rx_level <= CNT_W'(DEPTH)));

  assert_tx_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RA_TXD && ctrl_en && tx_full) |=> raw[IB_TXOVF]);

  assert_rx_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == RA_RXD && rx_empty) |=> raw[IB_RXUDF]);

  assert_thr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl_en |=> ($stable(tx_thr) && $stable(rx_thr)));

  assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(mask) != '0));

  assert_dma_tx_enabled_R11: assert property (@(posedge clk) disable iff (rst)
    dma_tx_req |-> $past(dma_en[DE_TX]));

  assert_flush_when_off_R12: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> (tx_level == '0 && rx_level == '0));

endmodule

bind spi_fifo_stat spi_fifo_stat_chk #(
  .DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W), .THR_W(THR_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .ctrl_en(ctrl_en_q), .tx_full(tx_full), .rx_empty(rx_empty),
  .raw(raw), .mask(mask_q), .tx_level(tx_level), .rx_level(rx_level),
  .tx_thr(tx_thr_q), .rx_thr(rx_thr_q), .dma_en(dma_en_q),
  .dma_tx_req(dma_tx_req), .irq(irq)
);

// File: tb/spi_fifo_stat_bench.sv
module spi_fifo_stat_bench;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int AW     = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              eng_busy = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [DATA_W-1:0] eng_tx_data, eng_rx_data = '0;
  logic              eng_tx_valid, irq, dma_tx_req, dma_rx_req;

  always #2.5 clk = ~clk;

  spi_fifo_stat #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_spi_fifo_stat (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .irq(irq),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  int checks = 0, fails = 0;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rx_push(input logic [DATA_W-1:0] d);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic tx_pop(output logic [DATA_W-1:0] d);
    @(negedge clk);
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
    d = eng_tx_data;
  endtask

  // op: 0 write, 1 read and compare, 2 engine RX push, 3 engine TX pop and compare
  localparam int NV = 29;
  localparam logic [41:0] VEC [NV] = '{
    {2'd1, 4'd1,  4'd5,  16'h00, 16'h0C},  // R1 status after reset
    {2'd1, 4'd1,  4'd8,  16'h00, 16'h01},  // R1 raw after reset
    {2'd1, 4'd1,  4'd3,  16'h00, 16'h00},  // R1 TX level
    {2'd0, 4'd8,  4'd1,  16'h01, 16'h00},  // R8 TX threshold 1
    {2'd1, 4'd8,  4'd1,  16'h00, 16'h01},
    {2'd0, 4'd8,  4'd1,  16'h04, 16'h00},  // R8 out of range
    {2'd1, 4'd8,  4'd1,  16'h00, 16'h01},
    {2'd0, 4'd6,  4'd2,  16'h01, 16'h00},  // R6 RX threshold 1
    {2'd0, 4'd12, 4'd0,  16'h01, 16'h00},  // enable
    {2'd0, 4'd8,  4'd1,  16'h02, 16'h00},  // R8 locked while enabled
    {2'd1, 4'd8,  4'd1,  16'h00, 16'h01},
    {2'd0, 4'd2,  4'd13, 16'h11, 16'h00},  // R2 push TX
    {2'd0, 4'd2,  4'd13, 16'h22, 16'h00},
    {2'd1, 4'd2,  4'd3,  16'h00, 16'h02},  // R2 TX level 2
    {2'd1, 4'd7,  4'd8,  16'h00, 16'h00},  // R7 level 2 above threshold 1
    {2'd3, 4'd2,  4'd0,  16'h00, 16'h11},  // R2 order
    {2'd1, 4'd7,  4'd8,  16'h00, 16'h01},  // R7 level 1 at threshold
    {2'd3, 4'd2,  4'd0,  16'h00, 16'h22},
    {2'd2, 4'd6,  4'd0,  16'hA5, 16'h00},  // R6 one word
    {2'd1, 4'd6,  4'd8,  16'h00, 16'h01},  // R6 not above threshold
    {2'd2, 4'd6,  4'd0,  16'h5A, 16'h00},
    {2'd1, 4'd6,  4'd8,  16'h00, 16'h11},  // R6 two words above threshold
    {2'd1, 4'd2,  4'd4,  16'h00, 16'h02},  // R2 RX level
    {2'd1, 4'd2,  4'd14, 16'h00, 16'hA5},  // R2 RX order
    {2'd1, 4'd2,  4'd14, 16'h00, 16'h5A},
    {2'd1, 4'd4,  4'd14, 16'h00, 16'h00},  // R4 empty read returns 0
    {2'd1, 4'd4,  4'd8,  16'h00, 16'h05},  // R4 underflow flag
    {2'd0, 4'd9,  4'd9,  16'h02, 16'h00},  // R9 clear underflow
    {2'd1, 4'd9,  4'd8,  16'h00, 16'h01}
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [DATA_W-1:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    check(1, {29'd0, irq, dma_tx_req, dma_rx_req}, 32'd0);  // R1

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      int req;
      op  = VEC[i][41:40];
      req = int'(VEC[i][39:36]);
      case (op)
        2'd0: wr(VEC[i][35:32], 32'(VEC[i][31:16]));
        2'd1: begin rd(VEC[i][35:32], v); check(req, v, 32'(VEC[i][15:0])); end
        2'd2: rx_push(VEC[i][23:16]);
        default: begin tx_pop(d); check(req, 32'(d), 32'(VEC[i][15:0])); end
      endcase
    end

    // R13 busy reflection
    eng_busy = 1'b1;
    rd(4'd5, v); check(13, v, 32'h0D);
    eng_busy = 1'b0;

    // R3 TX overflow: five writes into four slots
    for (int i = 1; i <= 5; i++) wr(4'd13, i);
    rd(4'd5, v); check(3, v, 32'h0A);
    rd(4'd8, v); check(3, v, 32'h02);
    for (int i = 1; i <= 4; i++) begin
      tx_pop(d); check(3, 32'(d), i);
    end
    rd(4'd3, v); check(3, v, 32'd0);

    // R5 RX overflow: six pushes into four slots
    for (int i = 0; i < 6; i++) rx_push(8'(8'h40 + i));
    rd(4'd5, v); check(5, v, 32'h14);
    rd(4'd8, v); check(5, v, 32'h1B);

    // R10 masking
    wr(4'd6, 32'h08); tick();
    check(10, 32'(irq), 32'd1);
    rd(4'd7, v); check(10, v, 32'h08);

    // R9 per-source and global clear
    wr(4'd9, 32'h08);
    rd(4'd8, v); check(9, v, 32'h19);
    wr(4'd9, 32'h01);
    rd(4'd8, v); check(9, v, 32'h11);
    check(10, 32'(irq), 32'd0);

    // R11 DMA watermarks
    wr(4'd11, 32'd1); wr(4'd12, 32'd1); wr(4'd10, 32'd3); tick();
    check(11, {30'd0, dma_tx_req, dma_rx_req}, 32'd3);
    for (int i = 0; i < 3; i++) rd(4'd14, v);
    check(2, v, 32'h42);
    tick();
    check(11, 32'(dma_rx_req), 32'd0);
    wr(4'd10, 32'd0); tick();
    check(11, 32'(dma_tx_req), 32'd0);

    // R12 disable flushes and drops
    wr(4'd0, 32'd0);
    rd(4'd4, v); check(12, v, 32'd0);
    wr(4'd13, 32'h77);
    rd(4'd3, v); check(12, v, 32'd0);
    rd(4'd5, v); check(12, v, 32'h0C);
    wr(4'd1, 32'd3);
    rd(4'd1, v); check(8, v, 32'd3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule